// File: doc/BRIEF.md
# Parity-Protected Translation Buffer Array

This block is the storage array of a translation lookaside buffer. It holds 64 entries. Each entry carries a 40-bit tag and two data words, a 26-bit first word and a 15-bit second word. Every entry also keeps eight even-parity bits in three groups: four for the tag, two for the first word and two for the second word. Writing an entry is the only way to change it, and every write recomputes the parity of the field it writes. Reads and lookups re-derive parity from the stored bits and compare it with the stored group.

Four operations share one request port. A write targets one field of one entry. A search compares a tag against all entries and reports whether any entry matches and which one. An indexed read returns one chosen field of one entry. A refill lookup returns the tag and both words of the matching entry. Each operation checks only the parity groups whose data it actually uses. A parity failure produces a one-cycle error pulse, an interrupt request when machine checks are enabled, and two sticky flags that hold until software clears them. A test-only injection port flips stored bits so that the error paths can be exercised.

Top module: `tlb_par_array`

## Requirements
- R1: A write (reqOp 0) to index i with reqWordSel 0, 1 or 2 replaces only the tag, the first word (reqData[25:0]) or the second word (reqData[14:0]) of entry i. The change takes effect at the next clock edge and produces no response. A write with reqWordSel 3 changes nothing.
- R2: Parity is even and is recomputed on every write. Tag parity bit k covers tag bits [10k+9:10k]. First-word bit k covers bits [13k+12:13k]. Second-word bit 0 covers bits [7:0] and bit 1 covers bits [14:8].
- R3: A search (reqOp 1) answers one cycle later with rspHit set and rspIndex set to the matching entry, or with rspHit clear and rspIndex 0 on a miss. rspData is 0 for a search. Only the tag parity of the matching entry is checked, and a miss raises no error.
- R4: A refill (reqOp 3) answers one cycle later with the matching entry's tag on rspData, its first word on rspW1 and its second word on rspW2. All three parity groups of that entry are checked. On a miss all of these outputs are 0 and no error is raised.
- R5: An indexed read (reqOp 2) of entry reqIndex returns the selected field on rspData, zero-extended, with rspHit set. Only that field's parity group is checked. reqWordSel 3 returns 0 and checks nothing.
- R6: When parityReturnEn is set with a read request, rspParity carries the stored parity group of the selected field, zero-extended. Otherwise rspParity is 0.
- R7: A failed check drives parErr high for exactly the response cycle. mcIrq is high in that cycle only if mcEnable is also high.
- R8: parErr sets stickyTlbErr and stickyMcSum at the next edge. They stay set until a cycle in which clearSticky is high and parErr is low. When both arrive together, setting wins.
- R9: rspValid is high exactly one cycle after a search, read or refill request, and never after a write.
- R10: When several entries match a tag, the lowest index is returned, and no error is reported for the multiple match.
- R11: With injValid high, entry injIndex has its stored bits XORed with injMask at the next edge, and parity is not recomputed. The mask is laid out from bit 0 upward as: tag [39:0], first word [65:40], second word [80:66], tag parity [84:81], first-word parity [86:85], second-word parity [88:87].
- R12: After reset, every entry and every parity bit is 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 write, 1 search, 2 read, 3 refill |
| reqIndex | input | 6 | Entry index for write and read |
| reqWordSel | input | 2 | 0 tag, 1 first word, 2 second word, 3 none |
| reqData | input | 40 | Write data or tag to compare |
| parityReturnEn | input | 1 | Return stored parity with read data |
| mcEnable | input | 1 | Machine-check interrupt enable |
| clearSticky | input | 1 | Clears the sticky flags |
| injValid | input | 1 | Fault-injection strobe |
| injIndex | input | 6 | Entry to corrupt |
| injMask | input | 89 | Bits to flip in that entry |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Match found (search/refill) or read done |
| rspIndex | output | 6 | Matched or read entry |
| rspData | output | 40 | Tag or selected word |
| rspParity | output | 4 | Stored parity of the read field |
| rspW1 | output | 26 | First word on refill |
| rspW2 | output | 15 | Second word on refill |
| parErr | output | 1 | Parity error pulse |
| mcIrq | output | 1 | Machine-check interrupt request |
| stickyTlbErr | output | 1 | Sticky array error flag |
| stickyMcSum | output | 1 | Sticky machine-check summary flag |

## Verification
The same corruption is presented to every operation type. A flipped tag bit must fail a search, a refill and a tag read, yet pass a first-word read. A flipped first-word bit must fail only a first-word read and a refill, while a search and a second-word read pass. A flipped stored parity bit must fail a refill. These patterns together separate the per-operation check masks, which a design that checks everything, or nothing, would get wrong. Duplicate tags, misses, the no-field read, a partial rewrite and a clear that coincides with a new error each test one boundary of the lookup and sticky logic.

// File: rtl/tlbParPkg.sv
package tlbParPkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SEARCH = 2'd1,
    OP_READ   = 2'd2,
    OP_REFILL = 2'd3
  } tlbOpE;

  typedef enum logic [1:0] {
    WS_TAG  = 2'd0,
    WS_W1   = 2'd1,
    WS_W2   = 2'd2,
    WS_NONE = 2'd3
  } wordSelE;

  // strobes valid in the request cycle
  typedef struct packed {
    logic    write;
    logic    lookup;   // search or refill: select by tag compare
    logic    byIndex;  // read: select by index
    wordSelE ws;
  } reqStbT;

  // strobes valid in the response cycle
  typedef struct packed {
    logic    valid;
    tlbOpE   op;
    wordSelE ws;
    logic    retPar;
  } rspStbT;

endpackage

// File: rtl/tlb_par_dp.sv
module tlb_par_dp
  import tlbParPkg::*;
#(
  parameter int NumEntries = 64,
  parameter int TagW       = 40,  // widest field; words are narrower
  parameter int W1W        = 26,
  parameter int W2W        = 15,
  parameter int TagGrp     = 4,
  parameter int W1Grp      = 2,
  parameter int W2Grp      = 2,
  localparam int IdxW      = $clog2(NumEntries),
  localparam int ParOutW   = (TagGrp > W1Grp) ? ((TagGrp > W2Grp) ? TagGrp : W2Grp)
                                              : ((W1Grp > W2Grp) ? W1Grp : W2Grp),
  localparam int EntW      = TagW + W1W + W2W + TagGrp + W1Grp + W2Grp
)(
  input  logic               clk,
  input  logic               rstN,
  input  reqStbT             reqStb,
  input  rspStbT             rspStb,
  input  logic [IdxW-1:0]    reqIndex,
  input  logic [TagW-1:0]    reqData,
  input  logic               injValid,
  input  logic [IdxW-1:0]    injIndex,
  input  logic [EntW-1:0]    injMask,
  output logic [2:0]         grpErr,
  output logic               rspHit,
  output logic [IdxW-1:0]    rspIndex,
  output logic [TagW-1:0]    rspData,
  output logic [ParOutW-1:0] rspParity,
  output logic [W1W-1:0]     rspW1,
  output logic [W2W-1:0]     rspW2
);

  localparam int W1Off  = TagW;
  localparam int W2Off  = W1Off + W1W;
  localparam int TpOff  = W2Off + W2W;
  localparam int P1Off  = TpOff + TagGrp;
  localparam int P2Off  = P1Off + W1Grp;

  // even parity over equal slices of ceil(w/g) bits
  function automatic logic [ParOutW-1:0] grpPar(input logic [TagW-1:0] v,
                                                 input int w, input int g);
    int s;
    logic [ParOutW-1:0] p;
    s = (w + g - 1) / g;
    p = '0;
    for (int i = 0; i < TagW; i++)
      if (i < w) p[i / s] = p[i / s] ^ v[i];
    return p;
  endfunction

  logic [TagW-1:0]   tagMem [NumEntries];
  logic [W1W-1:0]    w1Mem  [NumEntries];
  logic [W2W-1:0]    w2Mem  [NumEntries];
  logic [TagGrp-1:0] tpMem  [NumEntries];
  logic [W1Grp-1:0]  p1Mem  [NumEntries];
  logic [W2Grp-1:0]  p2Mem  [NumEntries];

  logic [ParOutW-1:0] wrTagPar, wrW1Par, wrW2Par;

  always_comb begin
    wrTagPar = grpPar(reqData, TagW, TagGrp);
    wrW1Par  = grpPar(TagW'(reqData[W1W-1:0]), W1W, W1Grp);
    wrW2Par  = grpPar(TagW'(reqData[W2W-1:0]), W2W, W2Grp);
  end

  // storage: write one field, or flip bits for fault injection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NumEntries; e++) begin
        tagMem[e] <= '0;
        w1Mem[e]  <= '0;
        w2Mem[e]  <= '0;
        tpMem[e]  <= '0;
        p1Mem[e]  <= '0;
        p2Mem[e]  <= '0;
      end
    end else if (reqStb.write) begin
      case (reqStb.ws)
        WS_TAG: begin
          tagMem[reqIndex] <= reqData;
          tpMem[reqIndex]  <= wrTagPar[TagGrp-1:0];
        end
        WS_W1: begin
          w1Mem[reqIndex] <= reqData[W1W-1:0];
          p1Mem[reqIndex] <= wrW1Par[W1Grp-1:0];
        end
        WS_W2: begin
          w2Mem[reqIndex] <= reqData[W2W-1:0];
          p2Mem[reqIndex] <= wrW2Par[W2Grp-1:0];
        end
        default: ;
      endcase
    end else if (injValid) begin
      tagMem[injIndex] <= tagMem[injIndex] ^ injMask[W1Off-1:0];
      w1Mem[injIndex]  <= w1Mem[injIndex]  ^ injMask[W2Off-1:W1Off];
      w2Mem[injIndex]  <= w2Mem[injIndex]  ^ injMask[TpOff-1:W2Off];
      tpMem[injIndex]  <= tpMem[injIndex]  ^ injMask[P1Off-1:TpOff];
      p1Mem[injIndex]  <= p1Mem[injIndex]  ^ injMask[P2Off-1:P1Off];
      p2Mem[injIndex]  <= p2Mem[injIndex]  ^ injMask[EntW-1:P2Off];
    end
  end

  // associative compare, lowest index wins, no multi-hit detection
  logic [NumEntries-1:0] matchVec;
  logic [IdxW-1:0]       matchIdx;
  logic                  matchAny;

  for (genvar e = 0; e < NumEntries; e++) begin : g_cmp
    assign matchVec[e] = (tagMem[e] == reqData);
  end

  always_comb begin
    matchIdx = '0;
    matchAny = |matchVec;
    for (int e = NumEntries - 1; e >= 0; e--)
      if (matchVec[e]) matchIdx = IdxW'(e);
  end

  logic [IdxW-1:0] selIdx;
  assign selIdx = reqStb.byIndex ? reqIndex : matchIdx;

  // capture the selected entry for the response cycle
  logic              regHit;
  logic [IdxW-1:0]   regIdx;
  logic [TagW-1:0]   regTag;
  logic [W1W-1:0]    regW1;
  logic [W2W-1:0]    regW2;
  logic [TagGrp-1:0] regTp;
  logic [W1Grp-1:0]  regP1;
  logic [W2Grp-1:0]  regP2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regHit <= 1'b0;
      regIdx <= '0;
      regTag <= '0;
      regW1  <= '0;
      regW2  <= '0;
      regTp  <= '0;
      regP1  <= '0;
      regP2  <= '0;
    end else begin
      regHit <= reqStb.byIndex | (reqStb.lookup & matchAny);
      regIdx <= selIdx;
      regTag <= tagMem[selIdx];
      regW1  <= w1Mem[selIdx];
      regW2  <= w2Mem[selIdx];
      regTp  <= tpMem[selIdx];
      regP1  <= p1Mem[selIdx];
      regP2  <= p2Mem[selIdx];
    end
  end

  // parity check of the captured entry, one flag per group
  logic [ParOutW-1:0] chkTag, chkW1, chkW2;

  always_comb begin
    chkTag = grpPar(regTag, TagW, TagGrp);
    chkW1  = grpPar(TagW'(regW1), W1W, W1Grp);
    chkW2  = grpPar(TagW'(regW2), W2W, W2Grp);
    grpErr = regHit ? {|(chkW2[W2Grp-1:0] ^ regP2),
                       |(chkW1[W1Grp-1:0] ^ regP1),
                       |(chkTag[TagGrp-1:0] ^ regTp)} : 3'b000;
  end

  // response formatting
  always_comb begin
    rspHit    = 1'b0;
    rspIndex  = '0;
    rspData   = '0;
    rspParity = '0;
    rspW1     = '0;
    rspW2     = '0;
    if (rspStb.valid) begin
      case (rspStb.op)
        OP_SEARCH: begin
          rspHit   = regHit;
          rspIndex = regHit ? regIdx : '0;
        end
        OP_REFILL: begin
          rspHit = regHit;
          if (regHit) begin
            rspIndex = regIdx;
            rspData  = regTag;
            rspW1    = regW1;
            rspW2    = regW2;
          end
        end
        OP_READ: begin
          rspHit   = 1'b1;
          rspIndex = regIdx;
          case (rspStb.ws)
            WS_TAG: begin
              rspData = regTag;
              if (rspStb.retPar) rspParity = ParOutW'(regTp);
            end
            WS_W1: begin
              rspData = TagW'(regW1);
              if (rspStb.retPar) rspParity = ParOutW'(regP1);
            end
            WS_W2: begin
              rspData = TagW'(regW2);
              if (rspStb.retPar) rspParity = ParOutW'(regP2);
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // checker state: re-derive parity of the entry last written
  logic            lastWr;
  logic [IdxW-1:0] lastWrIdx;
  logic [ParOutW-1:0] reTag, reW1, reW2;
  logic            wrOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWr    <= 1'b0;
      lastWrIdx <= '0;
    end else begin
      lastWr    <= reqStb.write;
      lastWrIdx <= reqIndex;
    end
  end

  always_comb begin
    reTag = grpPar(tagMem[lastWrIdx], TagW, TagGrp);
    reW1  = grpPar(TagW'(w1Mem[lastWrIdx]), W1W, W1Grp);
    reW2  = grpPar(TagW'(w2Mem[lastWrIdx]), W2W, W2Grp);
    wrOk  = (reTag[TagGrp-1:0] == tpMem[lastWrIdx]) &&
            (reW1[W1Grp-1:0]   == p1Mem[lastWrIdx]) &&
            (reW2[W2Grp-1:0]   == p2Mem[lastWrIdx]);
  end

  // R2: a freshly written entry holds consistent parity (bench never corrupts it beforehand)
  p_write_parity_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastWr |-> wrOk);

  // R12: reset leaves no pending hit
  p_reset_nohit_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !regHit);

endmodule

// File: rtl/tlb_par_ctrl.sv
module tlb_par_ctrl
  import tlbParPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqWordSel,
  input  logic       parityReturnEn,
  input  logic       mcEnable,
  input  logic       clearSticky,
  input  logic [2:0] grpErr,
  output reqStbT     reqStb,
  output rspStbT     rspStb,
  output logic       rspValid,
  output logic       parErr,
  output logic       mcIrq,
  output logic       stickyTlbErr,
  output logic       stickyMcSum
);

  tlbOpE   opIn;
  wordSelE wsIn;

  always_comb begin
    opIn           = tlbOpE'(reqOp);
    wsIn           = wordSelE'(reqWordSel);
    reqStb.write   = reqValid && (opIn == OP_WRITE) && (wsIn != WS_NONE);
    reqStb.lookup  = reqValid && ((opIn == OP_SEARCH) || (opIn == OP_REFILL));
    reqStb.byIndex = reqValid && (opIn == OP_READ);
    reqStb.ws      = wsIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspStb <= '0;
    end else begin
      rspStb.valid  <= reqValid && (opIn != OP_WRITE);
      rspStb.op     <= opIn;
      rspStb.ws     <= wsIn;
      rspStb.retPar <= parityReturnEn;
    end
  end

  // which parity groups each operation consumes
  logic [2:0] chkMask;

  always_comb begin
    case (rspStb.op)
      OP_SEARCH: chkMask = 3'b001;
      OP_REFILL: chkMask = 3'b111;
      OP_READ: begin
        case (rspStb.ws)
          WS_TAG:  chkMask = 3'b001;
          WS_W1:   chkMask = 3'b010;
          WS_W2:   chkMask = 3'b100;
          default: chkMask = 3'b000;
        endcase
      end
      default: chkMask = 3'b000;
    endcase
    rspValid = rspStb.valid;
    parErr   = rspStb.valid && |(grpErr & chkMask);
    mcIrq    = parErr && mcEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyTlbErr <= 1'b0;
      stickyMcSum  <= 1'b0;
    end else begin
      stickyTlbErr <= parErr | (stickyTlbErr & ~clearSticky);
      stickyMcSum  <= parErr | (stickyMcSum & ~clearSticky);
    end
  end

  // R8: flags hold without a clear
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stickyTlbErr && !clearSticky |=> stickyTlbErr);

  // R8: an error always lands in both flags
  p_err_sets_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    parErr |=> stickyTlbErr && stickyMcSum);

  // R7: no interrupt while machine checks are disabled
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mcEnable |-> !mcIrq);

  // R9: non-write request answers in the next cycle
  p_rsp_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqOp != 2'd0) |=> rspValid);

endmodule

// File: rtl/tlb_par_array.sv
module tlb_par_array
  import tlbParPkg::*;
#(
  parameter int NumEntries = 64,
  parameter int TagW       = 40,
  parameter int W1W        = 26,
  parameter int W2W        = 15,
  parameter int TagGrp     = 4,
  parameter int W1Grp      = 2,
  parameter int W2Grp      = 2,
  localparam int IdxW      = $clog2(NumEntries),
  localparam int ParOutW   = (TagGrp > W1Grp) ? ((TagGrp > W2Grp) ? TagGrp : W2Grp)
                                              : ((W1Grp > W2Grp) ? W1Grp : W2Grp),
  localparam int EntW      = TagW + W1W + W2W + TagGrp + W1Grp + W2Grp
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [IdxW-1:0]    reqIndex,
  input  logic [1:0]         reqWordSel,
  input  logic [TagW-1:0]    reqData,
  input  logic               parityReturnEn,
  input  logic               mcEnable,
  input  logic               clearSticky,
  input  logic               injValid,
  input  logic [IdxW-1:0]    injIndex,
  input  logic [EntW-1:0]    injMask,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IdxW-1:0]    rspIndex,
  output logic [TagW-1:0]    rspData,
  output logic [ParOutW-1:0] rspParity,
  output logic [W1W-1:0]     rspW1,
  output logic [W2W-1:0]     rspW2,
  output logic               parErr,
  output logic               mcIrq,
  output logic               stickyTlbErr,
  output logic               stickyMcSum
);

  reqStbT     reqStb;
  rspStbT     rspStb;
  logic [2:0] grpErr;

  tlb_par_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqOp         (reqOp),
    .reqWordSel    (reqWordSel),
    .parityReturnEn(parityReturnEn),
    .mcEnable      (mcEnable),
    .clearSticky   (clearSticky),
    .grpErr        (grpErr),
    .reqStb        (reqStb),
    .rspStb        (rspStb),
    .rspValid      (rspValid),
    .parErr        (parErr),
    .mcIrq         (mcIrq),
    .stickyTlbErr  (stickyTlbErr),
    .stickyMcSum   (stickyMcSum)
  );

  tlb_par_dp #(
    .NumEntries(NumEntries),
    .TagW      (TagW),
    .W1W       (W1W),
    .W2W       (W2W),
    .TagGrp    (TagGrp),
    .W1Grp     (W1Grp),
    .W2Grp     (W2Grp)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqStb   (reqStb),
    .rspStb   (rspStb),
    .reqIndex (reqIndex),
    .reqData  (reqData),
    .injValid (injValid),
    .injIndex (injIndex),
    .injMask  (injMask),
    .grpErr   (grpErr),
    .rspHit   (rspHit),
    .rspIndex (rspIndex),
    .rspData  (rspData),
    .rspParity(rspParity),
    .rspW1    (rspW1),
    .rspW2    (rspW2)
  );

endmodule

// File: tb/tlb_par_array_tb.sv
`timescale 1ns/1ps
module tlb_par_array_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [5:0]  reqIndex = '0;
  logic [1:0]  reqWordSel = '0;
  logic [39:0] reqData = '0;
  logic        parityReturnEn = 1'b0;
  logic        mcEnable = 1'b0;
  logic        clearSticky = 1'b0;
  logic        injValid = 1'b0;
  logic [5:0]  injIndex = '0;
  logic [88:0] injMask = '0;
  logic        rspValid, rspHit, parErr, mcIrq, stickyTlbErr, stickyMcSum;
  logic [5:0]  rspIndex;
  logic [39:0] rspData;
  logic [3:0]  rspParity;
  logic [25:0] rspW1;
  logic [14:0] rspW2;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  tlb_par_array u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIndex(reqIndex), .reqWordSel(reqWordSel), .reqData(reqData),
    .parityReturnEn(parityReturnEn), .mcEnable(mcEnable),
    .clearSticky(clearSticky), .injValid(injValid), .injIndex(injIndex),
    .injMask(injMask), .rspValid(rspValid), .rspHit(rspHit),
    .rspIndex(rspIndex), .rspData(rspData), .rspParity(rspParity),
    .rspW1(rspW1), .rspW2(rspW2), .parErr(parErr), .mcIrq(mcIrq),
    .stickyTlbErr(stickyTlbErr), .stickyMcSum(stickyMcSum)
  );

  // model of stored contents
  logic [39:0] mTag [64];
  logic [25:0] mW1  [64];
  logic [14:0] mW2  [64];

  function automatic logic [3:0] pf(input logic [39:0] v, input int w, input int s);
    logic [3:0] p;
    p = '0;
    for (int i = 0; i < w; i++) p[i / s] = p[i / s] ^ v[i];
    return p;
  endfunction

  task automatic chk(input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // drive one request; returns at the negedge of the response cycle
  task automatic req(input logic [1:0] op, input int idx,
                     input logic [1:0] ws, input logic [39:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIndex = 6'(idx);
    reqWordSel = ws; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [1:0] ws, input logic [39:0] d);
    req(2'd0, idx, ws, d);
    case (ws)
      2'd0: mTag[idx] = d;
      2'd1: mW1[idx]  = d[25:0];
      2'd2: mW2[idx]  = d[14:0];
      default: ;
    endcase
  endtask

  task automatic inject(input int idx, input int pos);
    @(negedge clk);
    injValid = 1'b1; injIndex = 6'(idx); injMask = '0; injMask[pos] = 1'b1;
    @(negedge clk);
    injValid = 1'b0; injMask = '0;
  endtask

  task automatic clearFlags();
    @(negedge clk); clearSticky = 1'b1;
    @(negedge clk); clearSticky = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "rspValid", 64'(rspValid), 0);
    chk("R12", "parErr", 64'(parErr), 0);
    chk("R12", "sticky", 64'({stickyTlbErr, stickyMcSum}), 0);
    chk("R12", "mcIrq", 64'(mcIrq), 0);
    parityReturnEn = 1'b1;
    req(2'd2, 7, 2'd0, '0);
    chk("R12", "read tag", 64'(rspData), 0);
    chk("R12", "parity", 64'(rspParity), 0);
    chk("R12", "no err", 64'(parErr), 0);
    parityReturnEn = 1'b0;
  endtask

  task automatic t_write_read();
    wr(3, 2'd0, 40'hA5_1234_5678);
    chk("R9", "no rsp after write", 64'(rspValid), 0);
    wr(3, 2'd1, 40'h2AB_CDEF);
    wr(3, 2'd2, 40'h5A5A);
    wr(9, 2'd0, 40'h00_FFFF_0001);
    wr(9, 2'd1, 40'h155_5555);
    wr(9, 2'd2, 40'h1234);
    for (int ws = 0; ws < 3; ws++) begin
      logic [39:0] e;
      req(2'd2, 3, 2'(ws), '0);
      e = (ws == 0) ? mTag[3] : (ws == 1) ? 40'(mW1[3]) : 40'(mW2[3]);
      chk("R5", "read data", 64'(rspData), 64'(e));
      chk("R9", "rspValid", 64'(rspValid), 1);
      chk("R6", "parity off", 64'(rspParity), 0);
      chk("R5", "no err", 64'(parErr), 0);
    end
    wr(9, 2'd1, 40'h0AA_0F0F);
    req(2'd2, 9, 2'd0, '0);
    chk("R1", "tag untouched", 64'(rspData), 64'(mTag[9]));
    req(2'd2, 9, 2'd2, '0);
    chk("R1", "w2 untouched", 64'(rspData), 64'(mW2[9]));
    req(2'd0, 9, 2'd3, 40'hFF_FFFF_FFFF);
    req(2'd2, 9, 2'd0, '0);
    chk("R1", "ws3 write ignored", 64'(rspData), 64'(mTag[9]));
    req(2'd2, 9, 2'd3, '0);
    chk("R5", "ws3 read zero", 64'(rspData), 0);
  endtask

  task automatic t_parity_return();
    parityReturnEn = 1'b1;
    req(2'd2, 3, 2'd0, '0);
    chk("R2", "tag parity", 64'(rspParity), 64'(pf(mTag[3], 40, 10)));
    req(2'd2, 3, 2'd1, '0);
    chk("R2", "w1 parity", 64'(rspParity), 64'(pf(40'(mW1[3]), 26, 13)));
    req(2'd2, 3, 2'd2, '0);
    chk("R6", "w2 parity", 64'(rspParity), 64'(pf(40'(mW2[3]), 15, 8)));
    parityReturnEn = 1'b0;
  endtask

  task automatic t_search();
    req(2'd1, 0, 2'd0, mTag[9]);
    chk("R3", "hit", 64'(rspHit), 1);
    chk("R3", "index", 64'(rspIndex), 9);
    chk("R3", "data zero", 64'(rspData), 0);
    chk("R9", "rspValid", 64'(rspValid), 1);
    req(2'd1, 0, 2'd0, 40'h12_3456_789A);
    chk("R3", "miss", 64'(rspHit), 0);
    chk("R3", "miss index", 64'(rspIndex), 0);
    chk("R3", "miss no err", 64'(parErr), 0);
  endtask

  task automatic t_refill();
    req(2'd3, 0, 2'd0, mTag[3]);
    chk("R4", "hit", 64'(rspHit), 1);
    chk("R4", "tag", 64'(rspData), 64'(mTag[3]));
    chk("R4", "w1", 64'(rspW1), 64'(mW1[3]));
    chk("R4", "w2", 64'(rspW2), 64'(mW2[3]));
    chk("R4", "no err", 64'(parErr), 0);
    req(2'd3, 0, 2'd0, 40'h12_3456_789A);
    chk("R4", "miss w1", 64'(rspW1), 0);
    chk("R4", "miss data", 64'(rspData), 0);
  endtask

  task automatic t_multi();
    wr(20, 2'd0, 40'h77);
    wr(12, 2'd0, 40'h77);
    req(2'd1, 0, 2'd0, 40'h77);
    chk("R10", "lowest index", 64'(rspIndex), 12);
    chk("R10", "no multi err", 64'(parErr), 0);
  endtask

  task automatic t_inject_tag();
    mcEnable = 1'b0;
    inject(9, 5);
    mTag[9] = mTag[9] ^ 40'h20;
    req(2'd1, 0, 2'd0, mTag[9]);
    chk("R11", "corrupt tag hit", 64'(rspIndex), 9);
    chk("R3", "tag err", 64'(parErr), 1);
    chk("R7", "irq masked", 64'(mcIrq), 0);
    @(negedge clk);
    chk("R7", "pulse ends", 64'(parErr), 0);
    chk("R8", "sticky set", 64'({stickyTlbErr, stickyMcSum}), 64'h3);
    repeat (3) @(negedge clk);
    chk("R8", "sticky holds", 64'({stickyTlbErr, stickyMcSum}), 64'h3);
    clearFlags();
    chk("R8", "sticky clear", 64'({stickyTlbErr, stickyMcSum}), 0);
    mcEnable = 1'b1;
    req(2'd2, 9, 2'd0, '0);
    chk("R5", "tag read err", 64'(parErr), 1);
    chk("R7", "irq", 64'(mcIrq), 1);
    clearSticky = 1'b1;
    @(negedge clk);
    clearSticky = 1'b0;
    chk("R8", "set wins", 64'(stickyTlbErr), 1);
    clearFlags();
    req(2'd2, 9, 2'd1, '0);
    chk("R5", "w1 read clean", 64'(parErr), 0);
    req(2'd3, 0, 2'd0, mTag[9]);
    chk("R4", "refill tag err", 64'(parErr), 1);
    clearFlags();
  endtask

  task automatic t_inject_word();
    inject(3, 40 + 4);
    mW1[3] = mW1[3] ^ 26'h10;
    req(2'd1, 0, 2'd0, mTag[3]);
    chk("R3", "search ignores w1", 64'(parErr), 0);
    req(2'd2, 3, 2'd2, '0);
    chk("R5", "w2 read clean", 64'(parErr), 0);
    req(2'd2, 3, 2'd1, '0);
    chk("R11", "w1 flipped", 64'(rspData), 64'(mW1[3]));
    chk("R5", "w1 read err", 64'(parErr), 1);
    req(2'd3, 0, 2'd0, mTag[3]);
    chk("R4", "refill w1 err", 64'(parErr), 1);
    wr(3, 2'd1, 40'h012_3456);
    req(2'd2, 3, 2'd1, '0);
    chk("R2", "rewrite fixes", 64'(parErr), 0);
    inject(12, 87);
    req(2'd3, 0, 2'd0, 40'h77);
    chk("R11", "parity bit flip", 64'(parErr), 1);
    clearFlags();
  endtask

  initial begin
    for (int e = 0; e < 64; e++) begin
      mTag[e] = '0; mW1[e] = '0; mW2[e] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_parity_return();
    t_search();
    t_refill();
    t_multi();
    t_inject_tag();
    t_inject_word();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule